// File: doc/BRIEF.md
# Translation Miss Resolution Handle

This block holds one software-visible command handle that parks a translation miss raised by a control block until software resolves it. When the handle is idle, a miss report from control block `n` is captured together with its virtual address, address-space identifier and cause. The handle then waits in one of two parked states. In fault-map mode the waiting control block is also flagged in a 128-entry fault bitmap. In user-polling mode only the handle state shows the miss.

Software first loads the fill fields for the translation entry: address-space identifier, virtual address, frame number, dirty flag, page-size code and access attribute. The frame number is the physical address shifted right by 12 for every page size. Access attributes are coded 0 RAM, 1 MMIO, 2 non-coherent RAM and 3 register. Software then writes the opcode with the start bit set in the same word, as the last write, and polls until the status leaves active. Depending on the opcode, the block emits a one-cycle translation-write strobe, a one-cycle restart pulse for the parked control block, or both in sequence.

Register words, indexed by `reg_*_addr`:
- Word 0 is the command word. Bit 0 is start, bits 6:4 the opcode, 17:16 the status, 22:20 the state, 30:24 the cause, 55:40 the control-block index and bit 56 the polling-mode flag.
- Word 1 is the captured miss address.
- Word 2 holds the miss identifier in bits 23:0, the fill identifier in 55:32, dirty in bit 56 and the attribute in 58:57.
- Word 3 holds the frame number in 40:0 and the page size in 52:48.
- Word 4 is the fill address.

Top module: `xmiss_handle`

## Requirements
- R1: After reset, word 0 reads zero (start 0, status 0 idle, state 0 inactive), both bitmaps are zero and `miss_ready` is low.
- R2: A word-0 write with bit 0 set makes the next read show start 1 and status 2 (active). A single-step command (opcode 0 noop, 7 polling, 4 exception) completes on the following edge with start 0 and status 0. Opcode 0 or 7 from state 0 or 1 gives state 1 (idle), and opcode 0 clears the polling flag.
- R3: In state 1 with polling off, a `miss_valid` is taken on one edge. The state becomes 3 (fault-map miss), the cause becomes 1 (or 2 when `miss_modify` is set), the index, address and identifier are captured, and fault bit [index] is set.
- R4: Opcode 7 sets the polling flag (word 0 bit 56). A later miss then parks in state 2 (polling miss) and leaves the fault bitmap unchanged.
- R5: Opcode 2 (write-only) spends one cycle in state 5, during which `tlb_wr_valid` is high with the fill fields. It then returns to the state it started from with status 0, and gives no restart pulse, so the fault bit stays set.
- R6: Opcode 3 (write-and-restart) gives state 5 with the write strobe, then state 6 with `cb_restart` high and `cb_restart_idx` set to the captured index, then state 1. On that last edge, fault bit [index] clears and done bit [index] sets.
- R7: Opcode 1 (restart) from a parked state gives only state 6 with the restart pulse and no write strobe, then state 1 with done bit [index] set.
- R8: Opcode 4 (exception) from a parked state returns to state 1 in one step. It clears fault bit [index], sets done bit [index] and issues no pulse.
- R9: An opcode that is undefined (5, 6), or not allowed in the current state, sets status 1 and cause 7 and leaves the state unchanged. Opcodes 0 and 7 need state 0 or 1. Opcode 2 needs state 1, 2 or 3. Opcodes 1 and 3 need state 2 or 3. Opcode 4 needs state 2, 3 or 4.
- R10: A miss report while the handle is not in state 1 or a command is running is ignored: `miss_ready` is low and the captured fields and bitmaps do not change.
- R11: In state 1 with no miss reported, `hwerr_valid` moves the handle to state 4 with the cause set to `hwerr_code`. Opcode 4 leaves state 4 for state 1.
- R12: Word-0 writes while start is 1 are ignored, so the running command and its opcode are unaffected.
- R13: Taking a miss from control block n clears done bit [n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register word index for writes |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_addr | input | 3 | Register word index for reads |
| reg_rd_data | output | 64 | Combinational read data |
| miss_valid | input | 1 | Miss report from a control block |
| miss_cb | input | 7 | Index of the reporting control block |
| miss_vaddr | input | 64 | Missing virtual address |
| miss_asid | input | 24 | Address-space identifier of the miss |
| miss_modify | input | 1 | Miss is a write to a clean entry (cause 2) |
| miss_ready | output | 1 | Handle can take a miss this cycle |
| hwerr_valid | input | 1 | Hardware error report |
| hwerr_code | input | 7 | Cause code of the hardware error |
| fault_bits | output | 128 | Per-control-block fault flags |
| done_bits | output | 128 | Per-control-block done flags |
| tlb_wr_valid | output | 1 | One-cycle translation write strobe |
| tlb_wr_asid | output | 24 | Fill identifier |
| tlb_wr_vaddr | output | 64 | Fill virtual address |
| tlb_wr_pfn | output | 41 | Fill frame number |
| tlb_wr_dirty | output | 1 | Fill dirty flag |
| tlb_wr_pgsz | output | 5 | Fill page-size code |
| tlb_wr_attr | output | 2 | Fill access attribute |
| cb_restart | output | 1 | One-cycle control-block restart pulse |
| cb_restart_idx | output | 7 | Control block to restart |

## Verification
The handle is driven through one long session that visits every parked state. Fault-map and polling misses show whether the bitmap marking depends on the mode. The three resolving opcodes are run from the same parked miss, and a scoreboard of expected write and restart pulses tells their pulse sequences apart: write only, write then restart, restart only, or nothing. Opcodes are also issued from the wrong states, undefined codes are tried, and word-0 writes are sent mid-command, to separate legal commands from rejected ones. Miss reports sent to a busy handle check that parked data is never overwritten.

// File: rtl/xmiss_pkg.sv
package xmiss_pkg;

  localparam logic [2:0] OP_NOOP    = 3'd0;
  localparam logic [2:0] OP_RESTART = 3'd1;
  localparam logic [2:0] OP_WRONLY  = 3'd2;
  localparam logic [2:0] OP_WRRST   = 3'd3;
  localparam logic [2:0] OP_EXCEPT  = 3'd4;
  localparam logic [2:0] OP_POLL    = 3'd7;

  localparam logic [6:0] CS_NONE   = 7'd0;
  localparam logic [6:0] CS_MISS   = 7'd1;
  localparam logic [6:0] CS_MODIFY = 7'd2;
  localparam logic [6:0] CS_INSTR  = 7'd7;

  localparam logic [2:0] W_CMD    = 3'd0;
  localparam logic [2:0] W_MISSVA = 3'd1;
  localparam logic [2:0] W_IDS    = 3'd2;
  localparam logic [2:0] W_FRAME  = 3'd3;
  localparam logic [2:0] W_FILLVA = 3'd4;

  typedef enum logic [1:0] {
    STS_IDLE   = 2'd0,
    STS_EXC    = 2'd1,
    STS_ACTIVE = 2'd2
  } sts_e;

  typedef enum logic [2:0] {
    ST_INACTIVE  = 3'd0,
    ST_IDLE      = 3'd1,
    ST_MISS_POLL = 3'd2,
    ST_MISS_FMAP = 3'd3,
    ST_HWERR     = 3'd4,
    ST_WRTLB     = 3'd5,
    ST_RESTART   = 3'd6
  } st_e;

  function automatic logic is_parked(st_e s);
    return (s == ST_MISS_POLL) || (s == ST_MISS_FMAP);
  endfunction

  function automatic logic op_ok(logic [2:0] op, st_e s);
    case (op)
      OP_NOOP, OP_POLL:     return (s == ST_INACTIVE) || (s == ST_IDLE);
      OP_WRONLY:            return (s == ST_IDLE) || is_parked(s);
      OP_RESTART, OP_WRRST: return is_parked(s);
      OP_EXCEPT:            return is_parked(s) || (s == ST_HWERR);
      default:              return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] pack_cmd(logic start, logic [2:0] op, sts_e sts,
                                           st_e st, logic [6:0] cause,
                                           logic [15:0] cb, logic poll);
    logic [63:0] w;
    w        = '0;
    w[0]     = start;
    w[6:4]   = op;
    w[17:16] = sts;
    w[22:20] = st;
    w[30:24] = cause;
    w[55:40] = cb;
    w[56]    = poll;
    return w;
  endfunction

endpackage

// File: rtl/xmiss_cmd_fsm.sv
module xmiss_cmd_fsm
  import xmiss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       cmd_start,
  input  logic [2:0] cmd_op,
  input  logic       miss_valid,
  input  logic       miss_modify,
  input  logic       hwerr_valid,
  input  logic [6:0] hwerr_code,
  output logic       start_o,
  output logic [2:0] op_o,
  output sts_e       sts_o,
  output st_e        st_o,
  output logic [6:0] cause_o,
  output logic       poll_o,
  output logic       ready_o,
  output logic       miss_take_o,
  output logic       resolve_o,
  output logic       tlb_wr_o,
  output logic       restart_o
);

  logic       start_q, poll_q;
  logic [2:0] op_q;
  logic [6:0] cause_q;
  sts_e       sts_q;
  st_e        st_q, park_q;

  logic exec, accept, legal, hw_take;

  assign accept      = cmd_wr && cmd_start && !start_q;
  assign exec        = start_q && (st_q != ST_WRTLB) && (st_q != ST_RESTART);
  assign legal       = op_ok(op_q, st_q);
  assign ready_o     = (st_q == ST_IDLE) && !start_q;
  assign miss_take_o = ready_o && miss_valid;
  assign hw_take     = ready_o && !miss_valid && hwerr_valid;
  assign tlb_wr_o    = (st_q == ST_WRTLB);
  assign restart_o   = (st_q == ST_RESTART);
  assign resolve_o   = (st_q == ST_RESTART) ||
                       (exec && legal && (op_q == OP_EXCEPT) && is_parked(st_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      poll_q  <= 1'b0;
      op_q    <= OP_NOOP;
      cause_q <= CS_NONE;
      sts_q   <= STS_IDLE;
      st_q    <= ST_INACTIVE;
      park_q  <= ST_IDLE;
    end else begin
      if (cmd_wr && !start_q) op_q <= cmd_op;
      if (accept) begin
        start_q <= 1'b1;
        sts_q   <= STS_ACTIVE;
      end else if (exec) begin
        if (!legal) begin
          start_q <= 1'b0;
          sts_q   <= STS_EXC;
          cause_q <= CS_INSTR;
        end else begin
          case (op_q)
            OP_WRONLY, OP_WRRST: begin
              park_q <= st_q;
              st_q   <= ST_WRTLB;
            end
            OP_RESTART: st_q <= ST_RESTART;
            default: begin
              st_q    <= ST_IDLE;
              start_q <= 1'b0;
              sts_q   <= STS_IDLE;
              if (op_q == OP_NOOP) poll_q <= 1'b0;
              if (op_q == OP_POLL) poll_q <= 1'b1;
            end
          endcase
        end
      end else if (st_q == ST_WRTLB) begin
        if (op_q == OP_WRRST) begin
          st_q <= ST_RESTART;
        end else begin
          st_q    <= park_q;
          start_q <= 1'b0;
          sts_q   <= STS_IDLE;
        end
      end else if (st_q == ST_RESTART) begin
        st_q    <= ST_IDLE;
        start_q <= 1'b0;
        sts_q   <= STS_IDLE;
      end

      if (miss_take_o) begin
        st_q    <= poll_q ? ST_MISS_POLL : ST_MISS_FMAP;
        cause_q <= miss_modify ? CS_MODIFY : CS_MISS;
      end else if (hw_take) begin
        st_q    <= ST_HWERR;
        cause_q <= hwerr_code;
      end
    end
  end

  assign start_o = start_q;
  assign op_o    = op_q;
  assign sts_o   = sts_q;
  assign st_o    = st_q;
  assign cause_o = cause_q;
  assign poll_o  = poll_q;

  a_r6_write_then_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_wr_o && op_q == OP_WRRST) |=> restart_o);

  a_r5_write_only_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_wr_o && op_q == OP_WRONLY) |=> (!restart_o && sts_q == STS_IDLE && !start_q));

  a_r9_illegal_op_exception: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !legal) |=> (sts_q == STS_EXC && cause_q == CS_INSTR && st_q == $past(st_q)));

  a_r12_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && cmd_wr) |=> (op_q == $past(op_q)));

endmodule

// File: rtl/xmiss_fill_regs.sv
module xmiss_fill_regs
  import xmiss_pkg::*;
#(
  parameter int CBW = 7,
  parameter int VAW = 64,
  parameter int ASW = 24,
  parameter int PFW = 41,
  parameter int PSW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [63:0]    wr_data,
  input  logic           miss_take,
  input  logic [CBW-1:0] miss_cb,
  input  logic [VAW-1:0] miss_vaddr,
  input  logic [ASW-1:0] miss_asid,
  output logic [CBW-1:0] cb_q,
  output logic [VAW-1:0] miss_va_q,
  output logic [ASW-1:0] miss_asid_q,
  output logic [ASW-1:0] fill_asid_q,
  output logic [VAW-1:0] fill_va_q,
  output logic [PFW-1:0] pfn_q,
  output logic           dirty_q,
  output logic [PSW-1:0] pgsz_q,
  output logic [1:0]     attr_q
);

  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_q        <= '0;
      miss_va_q   <= '0;
      miss_asid_q <= '0;
    end else if (miss_take) begin
      cb_q        <= miss_cb;
      miss_va_q   <= miss_vaddr;
      miss_asid_q <= miss_asid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_asid_q <= '0;
      fill_va_q   <= '0;
      pfn_q       <= '0;
      dirty_q     <= 1'b0;
      pgsz_q      <= '0;
      attr_q      <= 2'd0;
    end else if (wr_en) begin
      case (wr_addr)
        W_IDS: begin
          fill_asid_q <= wr_data[32 +: ASW];
          dirty_q     <= wr_data[56];
          attr_q      <= wr_data[58:57];
        end
        W_FRAME: begin
          pfn_q  <= wr_data[PFW-1:0];
          pgsz_q <= wr_data[48 +: PSW];
        end
        W_FILLVA: fill_va_q <= wr_data[VAW-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xmiss_fault_map.sv
module xmiss_fault_map #(
  parameter int NCB = 128,
  parameter int CBW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mark,
  input  logic           flag_fault,
  input  logic [CBW-1:0] mark_idx,
  input  logic           resolve,
  input  logic [CBW-1:0] res_idx,
  output logic [NCB-1:0] fault,
  output logic [NCB-1:0] done
);

  for (genvar i = 0; i < NCB; i++) begin : g_cb
    logic hit_mark, hit_res;
    assign hit_mark = mark && (mark_idx == CBW'(i));
    assign hit_res  = resolve && (res_idx == CBW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fault[i] <= 1'b0;
        done[i]  <= 1'b0;
      end else begin
        if (hit_mark && flag_fault) fault[i] <= 1'b1;
        else if (hit_res)           fault[i] <= 1'b0;
        if (hit_mark)               done[i]  <= 1'b0;
        else if (hit_res)           done[i]  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/xmiss_handle.sv
module xmiss_handle
  import xmiss_pkg::*;
#(
  parameter int NCB = 128,
  parameter int CBW = $clog2(NCB),
  parameter int VAW = 64,
  parameter int ASW = 24,
  parameter int PFW = 41,
  parameter int PSW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [2:0]     reg_wr_addr,
  input  logic [63:0]    reg_wr_data,
  input  logic [2:0]     reg_rd_addr,
  output logic [63:0]    reg_rd_data,
  input  logic           miss_valid,
  input  logic [CBW-1:0] miss_cb,
  input  logic [VAW-1:0] miss_vaddr,
  input  logic [ASW-1:0] miss_asid,
  input  logic           miss_modify,
  output logic           miss_ready,
  input  logic           hwerr_valid,
  input  logic [6:0]     hwerr_code,
  output logic [NCB-1:0] fault_bits,
  output logic [NCB-1:0] done_bits,
  output logic           tlb_wr_valid,
  output logic [ASW-1:0] tlb_wr_asid,
  output logic [VAW-1:0] tlb_wr_vaddr,
  output logic [PFW-1:0] tlb_wr_pfn,
  output logic           tlb_wr_dirty,
  output logic [PSW-1:0] tlb_wr_pgsz,
  output logic [1:0]     tlb_wr_attr,
  output logic           cb_restart,
  output logic [CBW-1:0] cb_restart_idx
);

  logic           cmd_wr, start_q, poll_q, miss_take, resolve;
  logic [2:0]     op_q;
  logic [6:0]     cause_q;
  sts_e           sts_q;
  st_e            st_q;
  logic [CBW-1:0] cb_q;
  logic [VAW-1:0] miss_va_q, fill_va_q;
  logic [ASW-1:0] miss_asid_q, fill_asid_q;
  logic [PFW-1:0] pfn_q;
  logic           dirty_q;
  logic [PSW-1:0] pgsz_q;
  logic [1:0]     attr_q;

  assign cmd_wr = reg_wr_en && (reg_wr_addr == W_CMD);

  xmiss_cmd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_start   (reg_wr_data[0]),
    .cmd_op      (reg_wr_data[6:4]),
    .miss_valid  (miss_valid),
    .miss_modify (miss_modify),
    .hwerr_valid (hwerr_valid),
    .hwerr_code  (hwerr_code),
    .start_o     (start_q),
    .op_o        (op_q),
    .sts_o       (sts_q),
    .st_o        (st_q),
    .cause_o     (cause_q),
    .poll_o      (poll_q),
    .ready_o     (miss_ready),
    .miss_take_o (miss_take),
    .resolve_o   (resolve),
    .tlb_wr_o    (tlb_wr_valid),
    .restart_o   (cb_restart)
  );

  xmiss_fill_regs #(
    .CBW(CBW), .VAW(VAW), .ASW(ASW), .PFW(PFW), .PSW(PSW)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .wr_addr     (reg_wr_addr),
    .wr_data     (reg_wr_data),
    .miss_take   (miss_take),
    .miss_cb     (miss_cb),
    .miss_vaddr  (miss_vaddr),
    .miss_asid   (miss_asid),
    .cb_q        (cb_q),
    .miss_va_q   (miss_va_q),
    .miss_asid_q (miss_asid_q),
    .fill_asid_q (fill_asid_q),
    .fill_va_q   (fill_va_q),
    .pfn_q       (pfn_q),
    .dirty_q     (dirty_q),
    .pgsz_q      (pgsz_q),
    .attr_q      (attr_q)
  );

  xmiss_fault_map #(.NCB(NCB), .CBW(CBW)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark       (miss_take),
    .flag_fault (!poll_q),
    .mark_idx   (miss_cb),
    .resolve    (resolve),
    .res_idx    (cb_q),
    .fault      (fault_bits),
    .done       (done_bits)
  );

  assign tlb_wr_asid    = fill_asid_q;
  assign tlb_wr_vaddr   = fill_va_q;
  assign tlb_wr_pfn     = pfn_q;
  assign tlb_wr_dirty   = dirty_q;
  assign tlb_wr_pgsz    = pgsz_q;
  assign tlb_wr_attr    = attr_q;
  assign cb_restart_idx = cb_q;

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_addr)
      W_CMD:    reg_rd_data = pack_cmd(start_q, op_q, sts_q, st_q, cause_q, 16'(cb_q), poll_q);
      W_MISSVA: reg_rd_data = 64'(miss_va_q);
      W_IDS: begin
        reg_rd_data[ASW-1:0]   = miss_asid_q;
        reg_rd_data[32 +: ASW] = fill_asid_q;
        reg_rd_data[56]        = dirty_q;
        reg_rd_data[58:57]     = attr_q;
      end
      W_FRAME: begin
        reg_rd_data[PFW-1:0]   = pfn_q;
        reg_rd_data[48 +: PSW] = pgsz_q;
      end
      W_FILLVA: reg_rd_data = 64'(fill_va_q);
      default: ;
    endcase
  end

  a_r10_busy_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_ready) |=> ($stable(miss_va_q) && $stable(fault_bits)));

  a_r4_poll_map_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_take && poll_q) |=> (fault_bits == $past(fault_bits)));

  a_r3_fmap_marks_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_take && !poll_q) |=> (fault_bits[$past(miss_cb)] == 1'b1));

endmodule

// File: tb/xmiss_handle_test.sv
module xmiss_handle_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [2:0]   reg_wr_addr = '0;
  logic [63:0]  reg_wr_data = '0;
  logic [2:0]   reg_rd_addr = '0;
  logic [63:0]  reg_rd_data;
  logic         miss_valid = 1'b0;
  logic [6:0]   miss_cb = '0;
  logic [63:0]  miss_vaddr = '0;
  logic [23:0]  miss_asid = '0;
  logic         miss_modify = 1'b0;
  logic         miss_ready;
  logic         hwerr_valid = 1'b0;
  logic [6:0]   hwerr_code = '0;
  logic [127:0] fault_bits, done_bits;
  logic         tlb_wr_valid, tlb_wr_dirty, cb_restart;
  logic [23:0]  tlb_wr_asid;
  logic [63:0]  tlb_wr_vaddr;
  logic [40:0]  tlb_wr_pfn;
  logic [4:0]   tlb_wr_pgsz;
  logic [1:0]   tlb_wr_attr;
  logic [6:0]   cb_restart_idx;

  always #2.5 clk = ~clk;

  xmiss_handle uut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          kind;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] c;
    string       req;
  } exp_t;
  exp_t q[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tlb_wr_valid || cb_restart) begin
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R7/R8 stray pulse: actual write=%0b restart=%0b expected none",
                   tlb_wr_valid, cb_restart);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.req, " pulse kind"}, {62'd0, cb_restart, tlb_wr_valid}, e.kind ? 64'd2 : 64'd1);
          if (!e.kind) begin
            chk({e.req, " fill vaddr"}, tlb_wr_vaddr, e.a);
            chk({e.req, " fill frame"}, 64'({tlb_wr_dirty, tlb_wr_attr, tlb_wr_pgsz, tlb_wr_pfn}), e.b);
            chk({e.req, " fill asid"}, 64'(tlb_wr_asid), e.c);
          end else begin
            chk({e.req, " restart index"}, 64'(cb_restart_idx), e.a);
          end
        end
      end
    end
  end

  task automatic push_wr(logic [63:0] va, logic [63:0] frm, logic [63:0] id, string req);
    exp_t e;
    e.kind = 1'b0; e.a = va; e.b = frm; e.c = id; e.req = req;
    q.push_back(e);
  endtask

  task automatic push_rst(logic [63:0] idx, string req);
    exp_t e;
    e.kind = 1'b1; e.a = idx; e.b = '0; e.c = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic launch(logic [2:0] op);
    wr(3'd0, (64'(op) << 4) | 64'd1);
  endtask

  task automatic rd(logic [2:0] a, output logic [63:0] d);
    reg_rd_addr = a;
    #0.5;
    d = reg_rd_data;
  endtask

  task automatic miss(logic [6:0] cb, logic [63:0] va, logic [23:0] id, logic m);
    @(negedge clk);
    miss_valid = 1'b1; miss_cb = cb; miss_vaddr = va; miss_asid = id; miss_modify = m;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic cmd_fields(string req, logic [2:0] st, logic [1:0] sts, logic start);
    logic [63:0] w;
    rd(3'd0, w);
    chk({req, " state"}, 64'(w[22:20]), 64'(st));
    chk({req, " status"}, 64'(w[17:16]), 64'(sts));
    chk({req, " start"}, 64'(w[0]), 64'(start));
  endtask

  task automatic cause_is(string req, logic [6:0] c);
    logic [63:0] w;
    rd(3'd0, w);
    chk({req, " cause"}, 64'(w[30:24]), 64'(c));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  localparam logic [63:0] VA_A  = 64'h0000_7f12_3456_7000;
  localparam logic [63:0] VA_B  = 64'h0000_5555_aaaa_0000;
  localparam logic [63:0] FV_1  = 64'h0000_7f12_3456_7000;
  localparam logic [63:0] FV_2  = 64'h0000_0bad_cafe_1000;
  localparam logic [40:0] PFN_1 = 41'h1_2345_6789;

  initial begin
    logic [63:0] w;
    logic [63:0] frm;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(3'd0, w);
    chk("R1 word0", w, 64'd0);
    chk("R1 fault map", 64'(fault_bits != 0), 64'd0);
    chk("R1 done map", 64'(done_bits != 0), 64'd0);
    chk("R1 miss_ready", 64'(miss_ready), 64'd0);

    // R9 restart from inactive is rejected; R2 active while pending
    launch(3'd1);
    cmd_fields("R2 launch pending", 3'd0, 2'd2, 1'b1);
    tick();
    cmd_fields("R9 restart while inactive", 3'd0, 2'd1, 1'b0);
    cause_is("R9 restart while inactive", 7'd7);

    // R2 noop enables the handle
    launch(3'd0);
    tick();
    cmd_fields("R2 noop", 3'd1, 2'd0, 1'b0);
    chk("R2 miss_ready", 64'(miss_ready), 64'd1);

    // R3 fault-map miss
    miss(7'd5, VA_A, 24'h00abcd, 1'b0);
    cmd_fields("R3 parked", 3'd3, 2'd0, 1'b0);
    cause_is("R3 miss cause", 7'd1);
    rd(3'd0, w);
    chk("R3 cb index", 64'(w[55:40]), 64'd5);
    rd(3'd1, w);
    chk("R3 miss vaddr", w, VA_A);
    rd(3'd2, w);
    chk("R3 miss asid", 64'(w[23:0]), 64'h00abcd);
    chk("R3 fault bit", 64'(fault_bits[5]), 64'd1);

    // R10 second miss while parked is ignored
    chk("R10 miss_ready low", 64'(miss_ready), 64'd0);
    miss(7'd9, VA_B, 24'h000111, 1'b1);
    rd(3'd1, w);
    chk("R10 vaddr kept", w, VA_A);
    chk("R10 no fault bit", 64'(fault_bits[9]), 64'd0);
    cause_is("R10 cause kept", 7'd1);

    // R5 write-only
    wr(3'd2, (64'h00beef << 32) | (64'd1 << 56) | (64'd2 << 57));
    wr(3'd3, 64'(PFN_1) | (64'd3 << 48));
    wr(3'd4, FV_1);
    frm = 64'({1'b1, 2'd2, 5'd3, PFN_1});
    push_wr(FV_1, frm, 64'h00beef, "R5");
    launch(3'd2);
    tick();
    cmd_fields("R5 writing", 3'd5, 2'd2, 1'b1);
    tick();
    cmd_fields("R5 back to parked", 3'd3, 2'd0, 1'b0);
    chk("R5 fault bit held", 64'(fault_bits[5]), 64'd1);

    // R6 write-and-restart, R12 command write while busy
    wr(3'd4, FV_2);
    push_wr(FV_2, frm, 64'h00beef, "R6");
    push_rst(64'd5, "R6");
    launch(3'd3);
    wr(3'd0, 64'd1);
    tick();
    cmd_fields("R6 complete", 3'd1, 2'd0, 1'b0);
    rd(3'd0, w);
    chk("R12 opcode kept", 64'(w[6:4]), 64'd3);
    chk("R6 fault cleared", 64'(fault_bits[5]), 64'd0);
    chk("R6 done set", 64'(done_bits[5]), 64'd1);

    // R4 polling mode
    launch(3'd7);
    tick();
    cmd_fields("R4 poll cmd", 3'd1, 2'd0, 1'b0);
    rd(3'd0, w);
    chk("R4 poll flag", 64'(w[56]), 64'd1);
    miss(7'd20, VA_B, 24'h000042, 1'b1);
    cmd_fields("R4 polling park", 3'd2, 2'd0, 1'b0);
    cause_is("R4 modify cause", 7'd2);
    chk("R4 no fault bit", 64'(fault_bits != 0), 64'd0);

    // R7 restart only
    push_rst(64'd20, "R7");
    launch(3'd1);
    tick();
    cmd_fields("R7 restarting", 3'd6, 2'd2, 1'b1);
    tick();
    cmd_fields("R7 complete", 3'd1, 2'd0, 1'b0);
    chk("R7 done set", 64'(done_bits[20]), 64'd1);

    // R13 new miss clears done; R8 exception opcode
    miss(7'd5, VA_A, 24'h000007, 1'b0);
    chk("R13 done cleared", 64'(done_bits[5]), 64'd0);
    cmd_fields("R13 parked", 3'd2, 2'd0, 1'b0);
    launch(3'd4);
    tick();
    cmd_fields("R8 exception", 3'd1, 2'd0, 1'b0);
    chk("R8 done set", 64'(done_bits[5]), 64'd1);
    chk("R8 no fault", 64'(fault_bits != 0), 64'd0);

    // R11 hardware error
    @(negedge clk);
    hwerr_valid = 1'b1; hwerr_code = 7'd4;
    @(negedge clk);
    hwerr_valid = 1'b0;
    cmd_fields("R11 hw error", 3'd4, 2'd0, 1'b0);
    cause_is("R11 hw cause", 7'd4);
    launch(3'd2);
    tick();
    cmd_fields("R9 write-only in hw error", 3'd4, 2'd1, 1'b0);
    cause_is("R9 write-only in hw error", 7'd7);
    launch(3'd4);
    tick();
    cmd_fields("R11 exception exits", 3'd1, 2'd0, 1'b0);

    // R9 undefined opcode
    launch(3'd5);
    tick();
    cmd_fields("R9 undefined opcode", 3'd1, 2'd1, 1'b0);
    cause_is("R9 undefined opcode", 7'd7);

    repeat (3) tick();
    chk("R6 all expected pulses seen", 64'(q.size()), 64'd0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule